// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block issues memory addresses from a pointer that can walk through a ring buffer. It holds three registers: a pointer, a base that marks the first word of the buffer, and a length that gives the buffer size in words. Each accepted access emits one address. A post-modify access emits the current pointer and then moves the pointer by a signed step. If the access asks for circular mode and the length is not zero, the new pointer folds back into the buffer within the same cycle. A pre-modify access emits pointer plus step and leaves the pointer unchanged.

Accesses enter through a valid/ready request port. Addresses leave through a valid/ready result port that has a single output register. An access is taken on a cycle where `acc_valid` and `acc_ready` are both high. `acc_ready` is high whenever the output register is empty or is being drained in that cycle. While `addr_valid` is high and `addr_ready` is low, the address is held steady and no new access is taken. Register writes use a plain port with no handshake and are always taken.

Top module: `cbag_top`

## Requirements
- R1: After reset the pointer, base and length all read as zero, and `addr_valid` is low.
- R2: A taken post-modify access (`acc_pre`=0) puts the current pointer on `addr_out` in the cycle after acceptance. The pointer then becomes its next value for the following access.
- R3: On a circular post-modify access with a non-zero length, if pointer+step ≥ base+length, the new pointer is pointer+step−length.
- R4: On a circular post-modify access with a non-zero length, if pointer+step < base, the new pointer is pointer+step+length.
- R5: A post-modify access with `acc_circ`=0 updates the pointer to pointer+step modulo 2^16 and never wraps.
- R6: A length of zero turns off wrapping, even for accesses that request circular mode.
- R7: A pre-modify access (`acc_pre`=1) emits pointer+step modulo 2^16, never wraps, and leaves the pointer unchanged.
- R8: A pointer write in the same cycle as a taken post-modify access wins over the post-modify update. That access still emits the old pointer. A base or length write takes effect from the next cycle onward.
- R9: `acc_ready` equals NOT `addr_valid` OR `addr_ready`. While `addr_valid` is high and `addr_ready` is low, `addr_out` holds steady. A result that is consumed with no new access taken clears `addr_valid`.
- R10: Register select codes are 0 for the pointer, 1 for the base and 2 for the length. A write with code 3 changes nothing.
- R11: The step is a signed two's-complement value. A step whose magnitude is larger than the length gives undefined circular results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 pointer, 1 base, 2 length, 3 none |
| wr_data | input | 16 | Register write value |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request can be taken |
| acc_step | input | 16 | Signed step for the access |
| acc_circ | input | 1 | Request circular wrapping |
| acc_pre | input | 1 | 1: pre-modify access, 0: post-modify access |
| addr_valid | output | 1 | Address output valid |
| addr_ready | input | 1 | Consumer takes the address |
| addr_out | output | 16 | Issued address |

## Verification
The clash that matters here is a pointer register write landing in the same cycle as a taken post-modify access. The write and the wrap both target the pointer. The bench provokes it with directed cycles that pair the two. It also draws the write strobe at random while accesses stream and the output port is randomly stalled. It judges the result by the address the access emits, which must be the old pointer, and by the address of the next access, which must be the written value. A second overlap is a drain and a new acceptance in the same cycle under back-pressure. It is judged by comparing `acc_ready`, `addr_valid` and `addr_out` every cycle against a reference model.

// File: rtl/cbag_pkg.sv
package cbag_pkg;
  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_BASE = 2'd1,
    SEL_LEN  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int NREG = 3;
endpackage

// File: rtl/cbag_wrap.sv
// Combinational address and next-pointer computation with single-cycle fold.
module cbag_wrap #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] step,
  input  logic          circ,
  input  logic          pre,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] nxt,
  output logic          wb
);
  localparam int EW = AW + 2;

  logic signed [EW-1:0] sum, bse, lenx, lim, adj;
  logic                 wrap_en;

  always_comb begin
    sum  = $signed({2'b00, ptr}) + $signed({{2{step[AW-1]}}, step});
    bse  = $signed({2'b00, base});
    lenx = $signed({2'b00, len});
    lim  = bse + lenx;
    wrap_en = circ && !pre && (len != '0);
    if (wrap_en && (sum >= lim))      adj = sum - lenx;
    else if (wrap_en && (sum < bse))  adj = sum + lenx;
    else                              adj = sum;
    nxt  = adj[AW-1:0];
    addr = pre ? sum[AW-1:0] : ptr;
    wb   = !pre;
  end
endmodule

// File: rtl/cbag_regs.sv
// Pointer, base and length registers; pointer write beats post-modify update.
module cbag_regs
  import cbag_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_val,
  output logic [AW-1:0] ptr_q,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] len_q
);
  logic [AW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_sel == 2'(g));
    if (g == int'(SEL_PTR)) begin : g_ptr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      regs_q[g] <= '0;
        else if (hit)    regs_q[g] <= wr_data;
        else if (upd_en) regs_q[g] <= upd_val;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   regs_q[g] <= '0;
        else if (hit) regs_q[g] <= wr_data;
      end
    end
  end

  assign ptr_q  = regs_q[int'(SEL_PTR)];
  assign base_q = regs_q[int'(SEL_BASE)];
  assign len_q  = regs_q[int'(SEL_LEN)];
endmodule

// File: rtl/cbag_out.sv
// One-entry output register with valid/ready.
module cbag_out #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_addr  <= in_addr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cbag_top.sv
module cbag_top #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic [AW-1:0] acc_step,
  input  logic          acc_circ,
  input  logic          acc_pre,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] addr_out
);
  logic [AW-1:0] ptr_q, base_q, len_q;
  logic [AW-1:0] calc_addr, calc_nxt;
  logic          calc_wb, fire;

  cbag_wrap #(.AW(AW)) u_wrap (
    .ptr(ptr_q), .base(base_q), .len(len_q), .step(acc_step),
    .circ(acc_circ), .pre(acc_pre),
    .addr(calc_addr), .nxt(calc_nxt), .wb(calc_wb)
  );

  assign fire = acc_valid && acc_ready;

  cbag_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .upd_en(fire && calc_wb), .upd_val(calc_nxt),
    .ptr_q(ptr_q), .base_q(base_q), .len_q(len_q)
  );

  cbag_out #(.AW(AW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(acc_valid), .in_ready(acc_ready), .in_addr(calc_addr),
    .out_valid(addr_valid), .out_ready(addr_ready), .out_addr(addr_out)
  );
endmodule

// File: rtl/cbag_chk.sv
module cbag_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic          acc_valid,
  input logic          acc_ready,
  input logic [AW-1:0] acc_step,
  input logic          acc_circ,
  input logic          acc_pre,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [AW-1:0] addr_out,
  input logic [AW-1:0] ptr_q,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] len_q
);
  localparam int EW = AW + 2;

  logic fire, ptr_wr, in_buf, step_ok;
  logic [EW-1:0] p_x, b_x, l_x, s_abs;

  always_comb begin
    fire   = acc_valid && acc_ready;
    ptr_wr = wr_en && (wr_sel == 2'd0);
    p_x = {2'b00, ptr_q};
    b_x = {2'b00, base_q};
    l_x = {2'b00, len_q};
    s_abs = acc_step[AW-1] ? {2'b00, (~acc_step + 1'b1)} : {2'b00, acc_step};
    in_buf  = (p_x >= b_x) && (p_x < b_x + l_x) && ((b_x + l_x) <= EW'(1 << AW));
    step_ok = s_abs <= l_x;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !addr_valid);

  assert_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> addr_valid);

  assert_stay_in_ring_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !acc_pre && acc_circ && len_q != '0 && in_buf && step_ok && !ptr_wr && !wr_en)
      |=> (ptr_q >= base_q) && ({2'b00, ptr_q} < {2'b00, base_q} + {2'b00, len_q}));

  assert_pre_keeps_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && acc_pre && !ptr_wr) |=> $stable(ptr_q));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_out)));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |-> !acc_ready);
endmodule

bind cbag_top cbag_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_step(acc_step),
  .acc_circ(acc_circ), .acc_pre(acc_pre), .addr_valid(addr_valid),
  .addr_ready(addr_ready), .addr_out(addr_out),
  .ptr_q(ptr_q), .base_q(base_q), .len_q(len_q)
);

// File: tb/tb_cbag_top.sv
module tb_cbag_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = '0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [15:0] acc_step = '0;
  logic        acc_circ = 1'b0;
  logic        acc_pre = 1'b0;
  logic        addr_valid;
  logic        addr_ready = 1'b1;
  logic [15:0] addr_out;

  always #5 clk = ~clk;

  cbag_top dut (.*);

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // reference state
  logic [15:0] m_ptr = '0, m_base = '0, m_len = '0, m_addr = '0;
  logic        m_av = 1'b0;
  logic [15:0] n_ptr, n_base, n_len, n_addr;
  logic        n_av;

  function automatic logic [15:0] f_next(logic [15:0] p, logic [15:0] b, logic [15:0] l,
                                         logic [15:0] s, logic circ);
    int sum, lo, hi;
    sum = int'(p) + int'($signed(s));
    lo = int'(b);
    hi = int'(b) + int'(l);
    if (circ && l != 0) begin
      if (sum >= hi)     sum = sum - int'(l);   // R3
      else if (sum < lo) sum = sum + int'(l);   // R4
    end
    return sum[15:0];                           // R5 linear modulo 2^16
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: called just after a negedge, with the model current
  task automatic cyc(string tag, bit we, logic [1:0] sel, logic [15:0] wd,
                     bit av, logic [15:0] st, bit circ, bit pre, bit ardy);
    bit fire;
    chk({tag, " addr_valid (R9)"}, {15'd0, addr_valid}, {15'd0, m_av});
    if (m_av) chk({tag, " addr_out"}, addr_out, m_addr);
    wr_en = we; wr_sel = sel; wr_data = wd;
    acc_valid = av; acc_step = st; acc_circ = circ; acc_pre = pre; addr_ready = ardy;
    #1;
    chk({tag, " acc_ready R9"}, {15'd0, acc_ready}, {15'd0, (!m_av || ardy)});
    fire = av && (!m_av || ardy);
    n_ptr = m_ptr; n_base = m_base; n_len = m_len; n_av = m_av; n_addr = m_addr;
    if (fire && !pre) n_ptr = f_next(m_ptr, m_base, m_len, st, circ);       // R2
    if (we && sel == 2'd0) n_ptr = wd;                                      // R8, R10
    if (we && sel == 2'd1) n_base = wd;
    if (we && sel == 2'd2) n_len = wd;
    if (fire) begin
      n_av = 1'b1;
      n_addr = pre ? 16'(int'(m_ptr) + int'($signed(st))) : m_ptr;          // R7
    end else if (ardy) n_av = 1'b0;
    @(negedge clk);
    m_ptr = n_ptr; m_base = n_base; m_len = n_len; m_av = n_av; m_addr = n_addr;
  endtask

  task automatic wreg(logic [1:0] sel, logic [15:0] d);
    cyc("wr", 1'b1, sel, d, 1'b0, '0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic acc(string tag, logic [15:0] st, bit circ, bit pre);
    cyc(tag, 1'b0, 2'd0, '0, 1'b1, st, circ, pre, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 addr_valid", {15'd0, addr_valid}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: registers zero -> post access gives address 0
    acc("R1 ptr zero", 16'd0, 1'b0, 1'b0);
    // R10 setup
    wreg(2'd1, 16'd100); wreg(2'd2, 16'd10); wreg(2'd0, 16'd108);
    acc("R2 post", 16'd3, 1'b1, 1'b0);        // emits 108, ptr -> 101 (R3)
    acc("R3 upper wrap", -16'sd5, 1'b1, 1'b0); // emits 101, ptr -> 106 (R4)
    acc("R4 lower wrap", 16'd0, 1'b1, 1'b0);   // emits 106
    acc("R5 linear", 16'd7, 1'b0, 1'b0);       // emits 106, ptr 113
    acc("R5 check", 16'd0, 1'b0, 1'b0);        // emits 113
    wreg(2'd0, 16'd109);
    acc("R7 pre", 16'd4, 1'b1, 1'b1);          // emits 113, no wrap
    acc("R7 unchanged", 16'd0, 1'b0, 1'b0);    // emits 109
    wreg(2'd3, 16'd5);                         // R10 ignored
    acc("R10 ignored", 16'd2, 1'b1, 1'b0);     // emits 109, ptr 101
    wreg(2'd2, 16'd0);                         // R6 length zero
    acc("R6 no wrap", 16'd20, 1'b1, 1'b0);     // emits 101 -> 121
    acc("R6 check", 16'd0, 1'b1, 1'b0);        // emits 121
    // R8 collision: pointer write with post access
    cyc("R8 collide", 1'b1, 2'd0, 16'd500, 1'b1, 16'd3, 1'b0, 1'b0, 1'b1);
    acc("R8 after", 16'd0, 1'b0, 1'b0);        // emits 500
    // R9 back-pressure
    cyc("R9 stall", 1'b0, 2'd0, '0, 1'b1, 16'd1, 1'b0, 1'b0, 1'b0);
    cyc("R9 held", 1'b0, 2'd0, '0, 1'b1, 16'd1, 1'b0, 1'b0, 1'b0);
    cyc("R9 drain", 1'b0, 2'd0, '0, 1'b0, 16'd1, 1'b0, 1'b0, 1'b1);
    cyc("R9 empty", 1'b0, 2'd0, '0, 1'b0, 16'd0, 1'b0, 1'b0, 1'b1);
    // random phase: R3 R4 R11 step magnitude bounded by length
    wreg(2'd1, 16'd2000); wreg(2'd2, 16'd32); wreg(2'd0, 16'd2010);
    for (int i = 0; i < 4000; i++) begin
      bit we; logic [1:0] sel; logic [15:0] wd, st; int mag;
      we = ($urandom % 16) == 0;
      sel = 2'($urandom % 4);
      wd = 16'($urandom);
      if (we && sel == 2'd2) wd = (($urandom % 8) == 0) ? 16'd0 : 16'(1 + $urandom % 64);
      if (we && sel == 2'd1) wd = 16'($urandom % 60000);
      if (we && sel == 2'd0) wd = m_base + ((m_len != 0) ? 16'($urandom % m_len) : 16'd0);
      mag = (m_len == 0) ? int'($urandom % 100) : int'($urandom % (int'(m_len) + 1));
      st = ($urandom % 2) ? 16'(-mag) : 16'(mag);
      cyc("rand R3/R4/R8", we, sel, wd, ($urandom % 4) != 0, st,
          ($urandom % 4) != 0, ($urandom % 6) == 0, ($urandom % 3) != 0);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule